// File: doc/BRIEF.md
# Round-Robin Pattern Stream Issuer

This block turns predicted spatial footprints into a stream of cache-block read requests. Each prediction arrives as a region base address and a bit vector, with one bit per 64-byte block of the region. The block keeps it in one of a small set of prediction registers. Every register that still has pending bits competes for a single request port. The registers take turns in round-robin order. Within a register, the pending blocks go out from the lowest index upward.

Each accepted request clears its bit. When a register's vector reaches zero, the register becomes free for the next prediction. A counter of outstanding requests throttles issue, and a completion pulse returns credit. Predictions that find every register busy are dropped and counted. Busy and full flags tell the prediction table how much room is left.

Top module: `pattern_stream_issuer`

## Requirements
- R1: After reset, req_valid, busy and full are 0 and drop_count is 0.
- R2: A load with a nonzero pattern is stored in the lowest-numbered free register. A load whose pattern is all zero occupies no register and leaves drop_count unchanged.
- R3: The request address for a register is its base with the low 6 bits cleared, plus 64 times the index of the lowest set pattern bit (bit 0 is the first block of the region).
- R4: When a request is accepted (req_valid and req_ready both high at a clock edge), the issued bit is cleared. A register whose bits are all clear is free again, and busy falls once no register holds a pending bit.
- R5: Active registers are served in round-robin order starting after the last served register. Empty registers are skipped, and at most one request is issued per cycle.
- R6: While req_valid is high and req_ready is low, req_valid stays high and req_addr does not change, provided no load arrives.
- R7: A nonzero load that arrives while all registers are busy is discarded. drop_count increments by one for it and saturates at its maximum (255 by default). Contents already held are not disturbed.
- R8: The outstanding count rises by one for each accepted request and falls by one for each done pulse. A done pulse at count 0 is ignored. req_valid is held low while the count is 16.
- R9: busy is high when any register holds a pending bit, and full is high when all 4 registers do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | New prediction present |
| load_base | input | AW | Region base address of the prediction |
| load_pattern | input | NBLK | Blocks predicted in the region, bit i = block i |
| req_valid | output | 1 | A block read request is offered |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | AW | 64-byte-aligned block address |
| done | input | 1 | One outstanding stream request completed |
| busy | output | 1 | At least one register still has pending blocks |
| full | output | 1 | No register is free |
| drop_count | output | DROP_W | Saturating count of discarded loads |

## Verification
A three-register mix is used, with sparse patterns of different lengths and an unaligned base. Its full drain order shows whether the selection rotates, skips empty slots, scans bits from the bottom and masks the base offset. A dense 32-bit pattern with no completions tells a correct 16-request ceiling apart from a counter that wrapped or went negative after a completion at zero. A burst of loads into four occupied registers separates discarding from overwriting, and it also reaches saturation of the drop count. The final drain shows the original bases still intact.

// File: rtl/pattern_stream_issuer.sv
module pattern_stream_issuer #(
  parameter int NREG      = 4,
  parameter int NBLK      = 32,
  parameter int AW        = 32,
  parameter int BLK_BYTES = 64,
  parameter int MAX_OUT   = 16,
  parameter int DROP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [AW-1:0]     load_base,
  input  logic [NBLK-1:0]   load_pattern,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  input  logic              done,
  output logic              busy,
  output logic              full,
  output logic [DROP_W-1:0] drop_count
);
  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int IDX_W = $clog2(NBLK);
  localparam int RW    = $clog2(NREG);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic [AW-1:0]   base_q [NREG];
  logic [NBLK-1:0] pend_q [NREG];
  logic [NREG-1:0] act;
  logic [RW-1:0]   ptr_q, sel, fidx;
  logic [IDX_W-1:0] bidx;
  logic [CNT_W-1:0] cnt_q;
  logic any_act, have_free, issue, ld_nz, ld_ok, dec;

  for (genvar i = 0; i < NREG; i++) begin : g_act
    assign act[i] = |pend_q[i];
  end

  always_comb begin
    any_act = 1'b0;
    sel = '0;
    for (int k = 0; k < NREG; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= NREG) j = j - NREG;
      if (!any_act && act[j]) begin
        any_act = 1'b1;
        sel = RW'(j);
      end
    end
    bidx = '0;
    for (int b = NBLK - 1; b >= 0; b--)
      if (pend_q[sel][b]) bidx = IDX_W'(b);
    have_free = 1'b0;
    fidx = '0;
    for (int f = NREG - 1; f >= 0; f--)
      if (!act[f]) begin
        have_free = 1'b1;
        fidx = RW'(f);
      end
  end

  assign busy      = |act;
  assign full      = &act;
  assign req_valid = any_act && (cnt_q < CNT_W'(MAX_OUT));
  assign req_addr  = (base_q[sel] & ~AW'(BLK_BYTES - 1)) + (AW'(bidx) << OFS_W);
  assign issue     = req_valid && req_ready;
  assign ld_nz     = load_valid && (|load_pattern);
  assign ld_ok     = ld_nz && have_free;
  assign dec       = done && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        pend_q[i] <= '0;
        base_q[i] <= '0;
      end
      ptr_q      <= '0;
      cnt_q      <= '0;
      drop_count <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (issue && sel == RW'(i)) pend_q[i][bidx] <= 1'b0;
        if (ld_ok && fidx == RW'(i)) begin
          pend_q[i] <= load_pattern;
          base_q[i] <= load_base;
        end
      end
      if (issue) ptr_q <= sel + RW'(1);
      if (issue && !dec) cnt_q <= cnt_q + CNT_W'(1);
      else if (!issue && dec) cnt_q <= cnt_q - CNT_W'(1);
      if (ld_nz && !have_free && drop_count != '1) drop_count <= drop_count + DROP_W'(1);
    end
  end

  // R8
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_OUT));

  // R8
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !done) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !load_valid) |=> (req_valid && $stable(req_addr)));

  // R7
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && (|load_pattern) && full && drop_count != '1)
      |=> drop_count == $past(drop_count) + DROP_W'(1));

  // R9
  full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> busy);
endmodule

// File: tb/pattern_stream_issuer_bench.sv
module pattern_stream_issuer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic load_valid = 1'b0, req_ready = 1'b0, done = 1'b0;
  logic [31:0] load_base = '0, load_pattern = '0;
  logic req_valid, busy, full;
  logic [31:0] req_addr;
  logic [7:0] drop_count;
  int checks = 0, fails = 0;

  localparam logic [31:0] EXP [7] = '{32'h1000, 32'h2080, 32'h3140, 32'h1040,
                                      32'h2100, 32'h10C0, 32'h2180};

  pattern_stream_issuer u_pattern_stream_issuer (
    .clk, .rst_n, .load_valid, .load_base, .load_pattern, .req_valid,
    .req_ready, .req_addr, .done, .busy, .full, .drop_count);

  always #2 clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; load_valid = 0; req_ready = 0; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic load(input logic [31:0] b, input logic [31:0] p);
    @(negedge clk);
    load_valid = 1'b1; load_base = b; load_pattern = p;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    @(negedge clk);
    chk("R1 valid", {31'b0, req_valid}, 0);
    chk("R1 busy", {30'b0, busy, full}, 0);
    chk("R1 drop", {24'b0, drop_count}, 0);

    load(32'h5000, 32'h0);
    chk("R2 zero pattern busy", {31'b0, busy}, 0);
    chk("R2 zero pattern drop", {24'b0, drop_count}, 0);

    load(32'h1023, 32'b1011);
    chk("R3 first addr", req_addr, 32'h1000);
    chk("R9 busy", {30'b0, busy, full}, 32'b10);
    load(32'h2000, 32'h54);
    load(32'h3000, 32'h20);
    @(negedge clk);
    chk("R6 held addr", req_addr, 32'h1000);
    chk("R6 held valid", {31'b0, req_valid}, 1);

    req_ready = 1'b1;
    for (int i = 0; i < 7; i++) begin
      chk("R5 stream", {req_valid, req_addr[30:0]}, {1'b1, EXP[i][30:0]});
      @(negedge clk);
    end
    chk("R4 drained", {30'b0, req_valid, busy}, 0);

    req_ready = 1'b0;
    done = 1'b1;
    repeat (8) @(negedge clk);
    done = 1'b0;
    load(32'h8000, 32'hFFFF_FFFF);
    req_ready = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (req_valid) n++;
      @(negedge clk);
    end
    chk("R8 limit issues", n, 16);
    chk("R8 stalled busy", {31'b0, busy}, 1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R8 credit addr", {req_valid, req_addr[30:0]}, {1'b1, 31'h8400});
    @(negedge clk);
    chk("R8 stall again", {31'b0, req_valid}, 0);

    do_reset();
    for (int i = 1; i <= 4; i++) load(32'h100 * i, 32'h1);
    chk("R9 full", {30'b0, busy, full}, 32'b11);
    load(32'h900, 32'h3);
    chk("R7 drop one", {24'b0, drop_count}, 1);
    @(negedge clk);
    load_valid = 1'b1; load_base = 32'h900; load_pattern = 32'h3;
    repeat (300) @(negedge clk);
    load_valid = 1'b0;
    chk("R7 saturate", {24'b0, drop_count}, 255);
    req_ready = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      chk("R7 kept contents", {req_valid, req_addr[30:0]}, {1'b1, 31'(32'h100 * i)});
      @(negedge clk);
    end
    chk("R4 free after drain", {30'b0, busy, req_valid}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule